// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplexer

This block holds eight single-bit storage cells that drive an eight-bit parallel output bus. A three-bit address picks one cell, and a serial data bit is steered into it. Two active-low controls select the operating mode: a write-enable and a functional clear. Depending on these controls the block writes the addressed bit and leaves the others alone, holds everything, acts as a one-of-eight demultiplexer with the unselected outputs forced low, or clears all bits.

The block is a clocked model built to be synthesized. All inputs are sampled on the rising clock edge, and the output register takes its new value at that same edge. A synchronous active-low reset clears the register at power-on. This reset is separate from the functional clear input. A typical use is serial-to-parallel assembly: eight writes load a byte, bit by bit, at chosen positions. The address should only change while the block is holding, so that a wrong bit is never selected.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low at a rising edge, all eight bits of `q` become 0, whatever the other inputs are.
- R2: The mode is chosen at each rising edge from (`clr_n`, `wr_en_n`): (1,0) is write, (1,1) is hold, (0,0) is demultiplex and (0,1) is clear. `q` shows the result of that edge straight after it.
- R3: In write mode, `q[addr]` takes the value of `din`, where `addr` is read as an unsigned binary index (0 selects `q[0]` and 7 selects `q[7]`). Every other bit keeps its value.
- R4: In hold mode, `q` does not change, whatever `din` and `addr` are doing.
- R5: In demultiplex mode, `q[addr]` takes the value of `din` and every other bit becomes 0.
- R6: In clear mode, all bits of `q` become 0, whatever `din` and `addr` are.
- R7: After a demultiplex cycle, hold mode keeps exactly the pattern that cycle left behind.
- R8: A series of write-mode cycles to different addresses builds up an arbitrary byte on `q`. Each write changes only its own bit position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| din | input | 1 | Serial data bit |
| addr | input | 3 | Index of the selected storage bit |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low functional clear |
| q | output | 8 | Parallel stored bits |

## Verification
In demultiplex mode, two effects fall in the same cycle: the write of the addressed bit and the clearing of every other bit. To provoke this, the bench first loads a dense pattern in write mode, so that every bit is 1 except possibly the target. It then applies a single demultiplex cycle at each address with both data polarities. The check passes only if, immediately after that edge, the addressed bit equals `din` and all seven other bits are 0. A following hold cycle then has to preserve that exact pattern.

// File: rtl/addr_latch_pkg.sv
// Package: shared mode type for the addressable latch.
// Assumes: the two active-low controls map onto four mutually exclusive modes.
package addr_latch_pkg;

    // Operating mode decoded from the clear and write-enable controls.
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } alat_mode_e;

endpackage

// File: rtl/alat_mode_decode.sv
// Module: alat_mode_decode
// Turns the active-low clear and write-enable inputs into one operating mode.
// Assumes: both inputs are already synchronous to the system clock.
module alat_mode_decode
    import addr_latch_pkg::*;
(
    input  logic       clr_n,
    input  logic       wr_en_n,
    output alat_mode_e mode
);

    // Purpose: choose one of four modes from the two control levels.
    always_comb begin
        unique case ({clr_n, wr_en_n})
            2'b10:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end

endmodule

// File: rtl/alat_addr_decode.sv
// Module: alat_addr_decode
// Binary-to-one-hot decoder that marks the storage bit chosen by the address.
// Assumes: NUM_BITS <= 2**ADDR_W, so an address at or past NUM_BITS selects nothing.
module alat_addr_decode #(
    parameter int NUM_BITS = 8,
    parameter int ADDR_W   = $clog2(NUM_BITS)
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_BITS-1:0] sel
);

    // Purpose: one equality comparator for each storage bit.
    for (genvar gi = 0; gi < NUM_BITS; gi++) begin : g_sel
        assign sel[gi] = (addr == ADDR_W'(gi));
    end

endmodule

// File: rtl/alat_bit_cell.sv
// Module: alat_bit_cell
// One storage bit: works out its next value from the mode and its select line,
// and registers that value.
// Assumes: rst_n is a synchronous active-low reset that clears the bit.
module alat_bit_cell
    import addr_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  alat_mode_e mode,
    input  logic       sel,
    input  logic       din,
    output logic       q
);

    logic q_next;

    // Purpose: next-state selection for one bit across the four modes.
    always_comb begin
        unique case (mode)
            MODE_WRITE: q_next = sel ? din : q;
            MODE_HOLD:  q_next = q;
            MODE_DEMUX: q_next = sel ? din : 1'b0;
            default:    q_next = 1'b0;
        endcase
    end

    // Purpose: storage flop with synchronous power-on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/addr_latch8.sv
// Module: addr_latch8 (top)
// Addressable latch with a one-of-N demultiplex mode. The inputs are sampled on
// the rising edge and the outputs update at that same edge.
// Assumes: the address changes only while in hold mode.
module addr_latch8
    import addr_latch_pkg::*;
#(
    parameter int NUM_BITS = 8,
    parameter int ADDR_W   = $clog2(NUM_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en_n,
    input  logic                clr_n,
    output logic [NUM_BITS-1:0] q
);

    alat_mode_e          mode;
    logic [NUM_BITS-1:0] sel;

    // Purpose: decode the control levels into the operating mode.
    alat_mode_decode u_mode (
        .clr_n   (clr_n),
        .wr_en_n (wr_en_n),
        .mode    (mode)
    );

    // Purpose: decode the address into one select line per bit.
    alat_addr_decode #(
        .NUM_BITS (NUM_BITS),
        .ADDR_W   (ADDR_W)
    ) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    // Purpose: one registered storage cell per output bit.
    for (genvar gb = 0; gb < NUM_BITS; gb++) begin : g_bit
        alat_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .sel   (sel[gb]),
            .din   (din),
            .q     (q[gb])
        );
    end

endmodule

// File: rtl/addr_latch8_checker.sv
// Module: addr_latch8_checker
// Temporal properties for addr_latch8, attached to it with bind.
// Assumes: the synchronous active-low reset is applied before the first check.
module addr_latch8_checker #(
    parameter int NUM_BITS = 8,
    parameter int ADDR_W   = $clog2(NUM_BITS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                din,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en_n,
    input logic                clr_n,
    input logic [NUM_BITS-1:0] q
);

    // R1: reset clears every bit by the next edge.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R3: a write updates the addressed bit.
    p_write_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !wr_en_n) |=> (q[$past(addr)] == $past(din)));

    // R8: a write leaves the unaddressed bits alone.
    p_write_others_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !wr_en_n) |=>
            ((q & ~(NUM_BITS'(1) << $past(addr))) ==
             ($past(q) & ~(NUM_BITS'(1) << $past(addr)))));

    // R4: hold mode changes nothing.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && wr_en_n) |=> $stable(q));

    // R5: demultiplex mode gives a single active bit at most, placed at the address.
    p_demux_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !wr_en_n) |=>
            (($countones(q) <= 1) && (q == (NUM_BITS'($past(din)) << $past(addr)))));

    // R6: clear mode zeroes the outputs.
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && wr_en_n) |=> (q == '0));

endmodule

bind addr_latch8 addr_latch8_checker #(
    .NUM_BITS (NUM_BITS),
    .ADDR_W   (ADDR_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .addr    (addr),
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .q       (q)
);

// File: tb/tb_addr_latch8.sv
module tb_addr_latch8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_latch8 dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .addr    (addr),
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .q       (q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive the inputs at the falling edge, then sample 1 ns after the next rising edge.
    task automatic step(input logic c_n, input logic w_n, input logic [2:0] a, input logic d);
        @(negedge clk);
        clr_n = c_n; wr_en_n = w_n; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), v[i]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; clr_n = 1'b1; wr_en_n = 1'b0; din = 1'b1; addr = 3'd4;
        @(posedge clk); #1;
        check("R1 reset clears", q, 8'h00);
        @(negedge clk); rst_n = 1'b1; wr_en_n = 1'b1;
    endtask

    task automatic t_serial_fill;
        logic [7:0] exp = 8'h00;
        logic [7:0] pat = 8'hA5;
        for (int i = 7; i >= 0; i--) begin
            step(1'b1, 1'b0, 3'(i), pat[i]);
            exp[i] = pat[i];
            check("R8 serial build", q, exp);
        end
        step(1'b1, 1'b0, 3'd2, 1'b1);
        check("R3 write one bit", q, 8'hA5 | 8'h04);
        step(1'b1, 1'b0, 3'd7, 1'b0);
        check("R3 write zero bit", q, 8'hA5 & 8'h7F | 8'h04);
    endtask

    task automatic t_hold;
        write_byte(8'h3C);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, 3'(i), i[0]);
            check("R4 hold ignores din/addr", q, 8'h3C);
        end
    endtask

    task automatic t_demux;
        for (int i = 0; i < 8; i++) begin
            for (int d = 0; d < 2; d++) begin
                write_byte(8'hFF);
                step(1'b1, 1'b0, 3'(i), 1'b0);
                step(1'b0, 1'b0, 3'(i), d[0]);
                check("R5 demux pattern", q, d[0] ? (8'h01 << i) : 8'h00);
            end
        end
    endtask

    task automatic t_demux_then_hold;
        write_byte(8'h5A);
        step(1'b0, 1'b0, 3'd6, 1'b1);
        check("R5 demux addr6", q, 8'h40);
        step(1'b1, 1'b1, 3'd6, 1'b1);
        check("R7 hold after demux", q, 8'h40);
        step(1'b1, 1'b1, 3'd1, 1'b0);
        check("R7 hold after demux, inputs moved", q, 8'h40);
    endtask

    task automatic t_clear;
        write_byte(8'hE7);
        step(1'b0, 1'b1, 3'd3, 1'b1);
        check("R6 clear", q, 8'h00);
        step(1'b0, 1'b1, 3'd0, 1'b0);
        check("R6 clear held", q, 8'h00);
    endtask

    task automatic t_mode_table;
        write_byte(8'h81);
        step(1'b1, 1'b0, 3'd3, 1'b1);
        check("R2 (1,0) write", q, 8'h89);
        step(1'b1, 1'b1, 3'd4, 1'b1);
        check("R2 (1,1) hold", q, 8'h89);
        step(1'b0, 1'b0, 3'd4, 1'b1);
        check("R2 (0,0) demux", q, 8'h10);
        step(1'b0, 1'b1, 3'd4, 1'b1);
        check("R2 (0,1) clear", q, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", q, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        t_serial_fill();
        t_hold();
        t_demux();
        t_demux_then_hold();
        t_clear();
        t_mode_table();
        t_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule